// File: doc/BRIEF.md
# Charger Protection Fault Sequencer

This block decides, cycle by cycle, whether the pass switches of a charger input stage may conduct. It takes already-digitised comparator flags (input undervoltage, input overvoltage, current limit active, battery overvoltage, over-temperature and sleep) plus a host request for the secondary switch. From these it drives a main-switch enable, a secondary-switch enable and a soft-stop request to the gate driver.

All timing runs from a one-microsecond tick divided down from the system clock. After the input leaves undervoltage, a power-on blanking wait must elapse before the switches close. Each of the three filtered faults has its own confirmation delay and its own release delay. Overcurrent recovery is a fixed wait followed by an automatic retry, which repeats for as long as the overload persists. Over-temperature and sleep act on the next clock edge. A status output holds the cause of the most recent shutdown.

Top module: `cps_fault_seq`

## Requirements
- R1: While `uvlo_i` is high, `main_en_o`, `sec_en_o` and `soft_stop_o` are low from the next cycle on, and every fault filter and timer is cleared. A battery-overvoltage recovery wait in progress therefore does not delay the next power-up.
- R2: After `uvlo_i` falls, `main_en_o` stays low for `BLANK_US` microseconds. At the end of that wait it rises only if `iovp_i` and `bovp_i` are both low. If either is high, it rises on the first cycle in which both are low.
- R3: `iovp_i` must stay high for `IOVP_DGL_US` microseconds before both enables drop.
- R4: After an input-overvoltage shutdown, the enables return only once `iovp_i` has stayed low for `IOVP_REC_US` microseconds.
- R5: `ocp_i` must stay high for `OCP_DGL_US` microseconds while the main switch is on before both enables drop.
- R6: After an overcurrent shutdown, the enables stay low for `OCP_REC_US` microseconds regardless of `ocp_i`. The block then re-enables the main switch, and the shutdown and retry cycle repeats while `ocp_i` stays high.
- R7: `bovp_i` must stay high for `BOVP_DGL_US` microseconds before shutdown. The enables return only after `bovp_i` has stayed low for `BOVP_REC_US` microseconds.
- R8: `therm_i` high turns both enables off on the next cycle. They return on the cycle after it falls, provided nothing else blocks them.
- R9: `sleep_i` high turns both enables off on the next cycle, whatever `host_on_i` requests.
- R10: `sec_en_o` is high only when the main switch is permitted and `host_on_i` is high. `host_on_i` low drops `sec_en_o` and leaves `main_en_o` untouched.
- R11: A shutdown caused by battery overvoltage or overcurrent raises `soft_stop_o` in the same cycle in which `main_en_o` falls, for `SSTOP_US` microseconds. Shutdowns for any other reason leave it low.
- R12: A fault flag that falls before its confirmation delay ends restarts that delay. A flag that rises during a flag-dependent recovery wait restarts that wait.
- R13: When `main_en_o` falls, `cause_o` records the highest-priority active reason. Encodings: 1 undervoltage, 2 thermal, 3 sleep, 4 input overvoltage, 5 battery overvoltage, 6 overcurrent. Priority runs in that same order, highest first. The value after reset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo_i | input | 1 | Input below undervoltage threshold |
| iovp_i | input | 1 | Input overvoltage comparator |
| ocp_i | input | 1 | Current limit active |
| bovp_i | input | 1 | Battery overvoltage comparator |
| therm_i | input | 1 | Over-temperature comparator |
| sleep_i | input | 1 | Input too close to output |
| host_on_i | input | 1 | Host request for the secondary switch |
| main_en_o | output | 1 | Main pass switch enable |
| sec_en_o | output | 1 | Secondary switch enable |
| soft_stop_o | output | 1 | Request a gradual main-switch turn-off |
| cause_o | output | 3 | Cause of the latest shutdown |

## Verification
A shutdown decision and the cause latch are made on the same edge. When two faults strike together, the recorded cause must follow the priority order and not whichever flag rose last. The bench raises thermal and sleep in one cycle and expects the thermal code.

The soft-stop request and the fall of `main_en_o` must also land on the same edge. The bench checks both in the window after the battery and overcurrent trips, and checks that soft-stop stays low for thermal, sleep, overvoltage and undervoltage shutdowns.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_UVLO  = 3'd1,
        CAUSE_THERM = 3'd2,
        CAUSE_SLEEP = 3'd3,
        CAUSE_IOVP  = 3'd4,
        CAUSE_BOVP  = 3'd5,
        CAUSE_OCP   = 3'd6
    } cause_e;

    typedef struct packed {
        logic uvlo;
        logic therm;
        logic sleep;
        logic iovp;
        logic bovp;
        logic ocp;
    } block_t;

    // Highest-priority reason among the active blockers.
    function automatic cause_e pick_cause(input block_t b);
        if (b.uvlo)       return CAUSE_UVLO;
        else if (b.therm) return CAUSE_THERM;
        else if (b.sleep) return CAUSE_SLEEP;
        else if (b.iovp)  return CAUSE_IOVP;
        else if (b.bovp)  return CAUSE_BOVP;
        else if (b.ocp)   return CAUSE_OCP;
        else              return CAUSE_NONE;
    endfunction

    function automatic logic wants_soft_stop(input cause_e c);
        return (c == CAUSE_BOVP) || (c == CAUSE_OCP);
    endfunction

endpackage

// File: rtl/cps_tick.sv
module cps_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (cnt == W'(DIV - 1)) begin
            cnt    <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/cps_fault_filter.sv
module cps_fault_filter #(
    parameter int DGL       = 8,
    parameter int REC       = 8,
    parameter bit TIMED_REC = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic tick_i,
    input  logic flag_i,
    output logic trip_o
);
    localparam int MAXV = (DGL > REC) ? DGL : REC;
    localparam int W    = $clog2(MAXV + 1);

    logic [W-1:0] cnt;
    logic         rec_hold;

    // Timed recovery ignores the flag; otherwise a raised flag restarts it.
    generate
        if (TIMED_REC) begin : g_timed
            assign rec_hold = 1'b0;
        end else begin : g_flag
            assign rec_hold = flag_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt    <= '0;
            trip_o <= 1'b0;
        end else if (!trip_o) begin
            if (!flag_i) begin
                cnt <= '0;
            end else if (tick_i) begin
                if (cnt == W'(DGL - 1)) begin
                    cnt    <= '0;
                    trip_o <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end else begin
            if (rec_hold) begin
                cnt <= '0;
            end else if (tick_i) begin
                if (cnt == W'(REC - 1)) begin
                    cnt    <= '0;
                    trip_o <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cps_fault_seq.sv
module cps_fault_seq
    import cps_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int BLANK_US    = 10_000,
    parameter int IOVP_DGL_US = 256,
    parameter int IOVP_REC_US = 8_200,
    parameter int OCP_DGL_US  = 8_200,
    parameter int OCP_REC_US  = 131_000,
    parameter int BOVP_DGL_US = 8_200,
    parameter int BOVP_REC_US = 131_000,
    parameter int SSTOP_US    = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       uvlo_i,
    input  logic       iovp_i,
    input  logic       ocp_i,
    input  logic       bovp_i,
    input  logic       therm_i,
    input  logic       sleep_i,
    input  logic       host_on_i,
    output logic       main_en_o,
    output logic       sec_en_o,
    output logic       soft_stop_o,
    output logic [2:0] cause_o
);
    localparam int TICK_DIV = CLK_HZ / 1_000_000;
    localparam int BW       = $clog2(BLANK_US + 1);
    localparam int SW       = $clog2(SSTOP_US + 1);

    logic          tick;
    logic          iovp_trip, bovp_trip, ocp_trip;
    logic [BW-1:0] blank_cnt;
    logic          blank_done, armed;
    logic [SW-1:0] ss_cnt;
    block_t        blk;
    logic          allow;
    cause_e        why, cause_q;

    cps_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick_o(tick)
    );

    cps_fault_filter #(.DGL(IOVP_DGL_US), .REC(IOVP_REC_US), .TIMED_REC(1'b0)) u_iovp (
        .clk(clk), .rst(rst), .clr_i(uvlo_i), .tick_i(tick),
        .flag_i(iovp_i), .trip_o(iovp_trip)
    );

    cps_fault_filter #(.DGL(BOVP_DGL_US), .REC(BOVP_REC_US), .TIMED_REC(1'b0)) u_bovp (
        .clk(clk), .rst(rst), .clr_i(uvlo_i), .tick_i(tick),
        .flag_i(bovp_i), .trip_o(bovp_trip)
    );

    // Current limit only matters while the main switch conducts.
    cps_fault_filter #(.DGL(OCP_DGL_US), .REC(OCP_REC_US), .TIMED_REC(1'b1)) u_ocp (
        .clk(clk), .rst(rst), .clr_i(uvlo_i), .tick_i(tick),
        .flag_i(ocp_i & main_en_o), .trip_o(ocp_trip)
    );

    // Power-on blanking and start gate.
    always_ff @(posedge clk) begin
        if (rst || uvlo_i) begin
            blank_cnt  <= '0;
            blank_done <= 1'b0;
            armed      <= 1'b0;
        end else begin
            if (!blank_done && tick) begin
                if (blank_cnt == BW'(BLANK_US - 1)) blank_done <= 1'b1;
                else                                 blank_cnt  <= blank_cnt + 1'b1;
            end
            if (blank_done && !armed && !iovp_i && !bovp_i) armed <= 1'b1;
        end
    end

    always_comb begin
        blk.uvlo  = uvlo_i;
        blk.therm = therm_i;
        blk.sleep = sleep_i;
        blk.iovp  = iovp_trip;
        blk.bovp  = bovp_trip;
        blk.ocp   = ocp_trip;
        allow     = armed && (blk == '0);
        why       = pick_cause(blk);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            main_en_o   <= 1'b0;
            sec_en_o    <= 1'b0;
            cause_q     <= CAUSE_NONE;
            soft_stop_o <= 1'b0;
            ss_cnt      <= '0;
        end else begin
            main_en_o <= allow;
            sec_en_o  <= allow && host_on_i;
            if (main_en_o && !allow) cause_q <= why;

            if (uvlo_i) begin
                soft_stop_o <= 1'b0;
                ss_cnt      <= '0;
            end else if (main_en_o && !allow && wants_soft_stop(why)) begin
                soft_stop_o <= 1'b1;
                ss_cnt      <= '0;
            end else if (soft_stop_o && tick) begin
                if (ss_cnt == SW'(SSTOP_US - 1)) soft_stop_o <= 1'b0;
                else                              ss_cnt      <= ss_cnt + 1'b1;
            end
        end
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/cps_fault_seq_chk.sv
module cps_fault_seq_chk
    import cps_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       uvlo_i,
    input logic       therm_i,
    input logic       sleep_i,
    input logic       host_on_i,
    input logic       main_en_o,
    input logic       sec_en_o,
    input logic       soft_stop_o,
    input logic [2:0] cause_o
);
    assert_uvlo_all_off_R1: assert property (@(posedge clk) disable iff (rst)
        uvlo_i |=> (!main_en_o && !sec_en_o && !soft_stop_o));

    assert_therm_off_R8: assert property (@(posedge clk) disable iff (rst)
        therm_i |=> !main_en_o);

    assert_sleep_off_R9: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> (!main_en_o && !sec_en_o));

    assert_host_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !host_on_i |=> !sec_en_o);

    assert_soft_stop_edge_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(soft_stop_o) |-> $fell(main_en_o));

    assert_soft_stop_off_R11: assert property (@(posedge clk) disable iff (rst)
        soft_stop_o |-> !main_en_o);

    assert_therm_cause_R13: assert property (@(posedge clk) disable iff (rst)
        ($fell(main_en_o) && $past(therm_i) && !$past(uvlo_i)) |-> (cause_o == 3'(CAUSE_THERM)));
endmodule

bind cps_fault_seq cps_fault_seq_chk u_chk (
    .clk(clk), .rst(rst), .uvlo_i(uvlo_i), .therm_i(therm_i), .sleep_i(sleep_i),
    .host_on_i(host_on_i), .main_en_o(main_en_o), .sec_en_o(sec_en_o),
    .soft_stop_o(soft_stop_o), .cause_o(cause_o)
);

// File: tb/tb_cps_fault_seq.sv
module tb_cps_fault_seq;
    localparam int D    = 4;     // clock cycles per microsecond tick
    localparam int BLK  = 20;
    localparam int IODG = 5;
    localparam int IORC = 12;
    localparam int OCDG = 10;
    localparam int OCRC = 30;
    localparam int BVDG = 8;
    localparam int BVRC = 25;
    localparam int SST  = 6;

    localparam logic [5:0] M_MAIN  = 6'b000001;
    localparam logic [5:0] M_SEC   = 6'b000010;
    localparam logic [5:0] M_SS    = 6'b000100;
    localparam logic [5:0] M_CAUSE = 6'b111000;
    localparam logic [5:0] M_EN    = 6'b000011;

    logic clk = 1'b0;
    logic rst;
    logic uvlo, iovp, ocp, bovp, therm, sleep, host;
    logic main_en, sec_en, soft_stop;
    logic [2:0] cause;

    always #2 clk = ~clk;

    cps_fault_seq #(
        .CLK_HZ(D * 1_000_000), .BLANK_US(BLK),
        .IOVP_DGL_US(IODG), .IOVP_REC_US(IORC),
        .OCP_DGL_US(OCDG), .OCP_REC_US(OCRC),
        .BOVP_DGL_US(BVDG), .BOVP_REC_US(BVRC),
        .SSTOP_US(SST)
    ) dut (
        .clk(clk), .rst(rst), .uvlo_i(uvlo), .iovp_i(iovp), .ocp_i(ocp),
        .bovp_i(bovp), .therm_i(therm), .sleep_i(sleep), .host_on_i(host),
        .main_en_o(main_en), .sec_en_o(sec_en), .soft_stop_o(soft_stop),
        .cause_o(cause)
    );

    typedef struct {
        int         cyc;
        logic [5:0] mask;
        logic [5:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int    cyc     = 0;
    int    n_chk   = 0;
    int    n_fail  = 0;

    wire [5:0] obs = {cause, soft_stop, sec_en, main_en};

    function automatic logic [5:0] pk(int c, bit ss, bit se, bit me);
        return {c[2:0], ss, se, me};
    endfunction

    // Driver side: expectation for the next falling edge.
    task automatic expect_out(logic [5:0] mask, logic [5:0] exp, string req);
        item_t it;
        it.cyc  = cyc + 1;
        it.mask = mask;
        it.exp  = exp;
        it.req  = req;
        q.push_back(it);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: compare at the falling edge, away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            item_t it;
            it = q.pop_front();
            n_chk = n_chk + 1;
            if ((obs & it.mask) !== (it.exp & it.mask)) begin
                n_fail = n_fail + 1;
                $display("FAIL %s cycle %0d actual=%b expected=%b mask=%b",
                         it.req, cyc, obs & it.mask, it.exp & it.mask, it.mask);
            end
        end
        if (cyc >= 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; uvlo = 1'b1; iovp = 1'b0; ocp = 1'b0; bovp = 1'b0;
        therm = 1'b0; sleep = 1'b0; host = 1'b1;
        wait_cyc(5);
        expect_out(6'b111111, pk(0, 0, 0, 0), "R13 reset state");
        wait_cyc(1);
        rst = 1'b0;
        wait_cyc(10);
        expect_out(M_EN | M_SS, pk(0, 0, 0, 0), "R1 held off in undervoltage");

        // R2: blanking, then start gated by battery flag
        uvlo = 1'b0;
        wait_cyc(70);
        expect_out(M_EN, pk(0, 0, 0, 0), "R2 off during blanking");
        wait_cyc(2);
        bovp = 1'b1;
        wait_cyc(12);
        expect_out(M_MAIN, pk(0, 0, 0, 0), "R2 start gated by bovp");
        bovp = 1'b0;
        wait_cyc(6);
        expect_out(M_EN, pk(0, 0, 1, 1), "R2 on after gate clears");

        // R10: host request only affects secondary
        host = 1'b0;
        wait_cyc(3);
        expect_out(M_EN, pk(0, 0, 0, 1), "R10 host off drops secondary");
        host = 1'b1;
        wait_cyc(3);
        expect_out(M_EN, pk(0, 0, 1, 1), "R10 host on restores secondary");

        // R8: thermal immediate, no soft stop
        therm = 1'b1;
        wait_cyc(3);
        expect_out(M_EN | M_SS | M_CAUSE, pk(2, 0, 0, 0), "R8 thermal off");
        therm = 1'b0;
        wait_cyc(3);
        expect_out(M_EN, pk(0, 0, 1, 1), "R8 thermal release");

        // R9: sleep overrides host request
        sleep = 1'b1;
        wait_cyc(3);
        expect_out(M_EN | M_SS | M_CAUSE, pk(3, 0, 0, 0), "R9 sleep off");
        sleep = 1'b0;
        wait_cyc(3);
        expect_out(M_EN, pk(0, 0, 1, 1), "R9 sleep release");

        // R13: simultaneous thermal and sleep
        therm = 1'b1; sleep = 1'b1;
        wait_cyc(3);
        expect_out(M_MAIN | M_CAUSE, pk(2, 0, 0, 0), "R13 thermal outranks sleep");
        therm = 1'b0; sleep = 1'b0;
        wait_cyc(3);

        // R12: short pulses restart the deglitch count
        iovp = 1'b1; wait_cyc(14);
        iovp = 1'b0; wait_cyc(4);
        iovp = 1'b1; wait_cyc(14);
        iovp = 1'b0;
        expect_out(M_MAIN, pk(0, 0, 0, 1), "R12 deglitch restarts");
        wait_cyc(10);

        // R3 / R4: input overvoltage
        iovp = 1'b1;
        wait_cyc(14);
        expect_out(M_MAIN, pk(0, 0, 0, 1), "R3 on inside deglitch");
        wait_cyc(10);
        expect_out(6'b111111, pk(4, 0, 0, 0), "R3 off after deglitch");
        wait_cyc(10);
        iovp = 1'b0; wait_cyc(20);
        iovp = 1'b1; wait_cyc(2);   // R12: reassert restarts recovery
        iovp = 1'b0;
        wait_cyc(42);
        expect_out(M_MAIN, pk(0, 0, 0, 0), "R4 R12 off inside recovery");
        wait_cyc(10);
        expect_out(M_EN, pk(0, 0, 1, 1), "R4 on after recovery");

        // R7 / R11: battery overvoltage with soft stop
        bovp = 1'b1;
        wait_cyc(26);
        expect_out(M_MAIN, pk(0, 0, 0, 1), "R7 on inside deglitch");
        wait_cyc(10);
        expect_out(6'b111111, pk(5, 1, 0, 0), "R7 R11 off with soft stop");
        wait_cyc(30);
        expect_out(M_SS, pk(0, 0, 0, 0), "R11 soft stop ends");
        bovp = 1'b0;
        wait_cyc(94);
        expect_out(M_MAIN, pk(0, 0, 0, 0), "R7 off inside recovery");
        wait_cyc(10);
        expect_out(M_EN, pk(0, 0, 1, 1), "R7 on after recovery");

        // R5 / R6: overcurrent and automatic retry
        ocp = 1'b1;
        wait_cyc(34);
        expect_out(M_MAIN, pk(0, 0, 0, 1), "R5 on inside deglitch");
        wait_cyc(10);
        expect_out(6'b111111, pk(6, 1, 0, 0), "R5 R11 off with soft stop");
        wait_cyc(106);
        expect_out(M_MAIN, pk(0, 0, 0, 0), "R6 off during recovery");
        wait_cyc(16);
        expect_out(M_MAIN, pk(0, 0, 0, 1), "R6 retry enables");
        wait_cyc(40);
        expect_out(M_MAIN | M_CAUSE, pk(6, 0, 0, 0), "R6 repeat shutdown");
        ocp = 1'b0;
        wait_cyc(130);
        expect_out(M_EN, pk(0, 0, 1, 1), "R6 on after overload gone");
        wait_cyc(60);
        expect_out(M_EN, pk(0, 0, 1, 1), "R6 stays on");

        // R1: undervoltage while running
        uvlo = 1'b1;
        wait_cyc(3);
        expect_out(6'b111111, pk(1, 0, 0, 0), "R1 undervoltage off");
        uvlo = 1'b0;
        wait_cyc(88);
        expect_out(M_EN, pk(0, 0, 1, 1), "R1 repower");
        bovp = 1'b1;
        wait_cyc(40);
        expect_out(M_MAIN, pk(0, 0, 0, 0), "R7 tripped before undervoltage");
        bovp = 1'b0;
        uvlo = 1'b1;
        wait_cyc(4);
        uvlo = 1'b0;
        wait_cyc(88);
        expect_out(M_MAIN, pk(0, 0, 0, 1), "R1 undervoltage cleared recovery");

        wait_cyc(3);
        while (q.size() > 0) wait_cyc(1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule